// File: doc/BRIEF.md
# Serial Temperature Sensor Slave

This block is a synchronous model of a small serial temperature sensor of the kind a host reaches by toggling two general-purpose pins. One pin is a slow serial clock and the other is a data line. The block runs on the system clock. It passes both serial pins through a synchroniser and turns each transition of the serial clock into a one-cycle event. Every frame has two halves. In the first half the block presents a 16-bit response word on its data output, one bit per falling serial-clock edge. In the second half it takes in a 16-bit configuration word, one bit per rising edge, most significant bit first.

The low byte of the configuration word chooses the response for the next frame. 0x00 selects a fixed temperature code, 0xFF selects a device identifier, and any other value is refused and flagged. The host may also ask the block to stay quiet for one frame. In that case the block goes through an idle phase of 16 rising edges and does not drive the line.

Top module: `tsense_slave`

## Requirements
- R1: Synchronous active-high reset clears the edge counter, the shift register, the configuration register and the invalid flag, and selects the output phase. After reset `sdo_oe_o` is 1, `sdo_o` is 0, `cfg_o` is 0 and `bad_cmd_o` is 0, and the reset takes effect in the middle of any frame.
- R2: `sclk_i` and `sdi_i` pass through a two-flop synchroniser. A level change on `sclk_i` takes effect on the third system clock edge after it is driven, and each transition counts as exactly one edge, including a low pulse that lasts one system clock cycle.
- R3: The output phase lasts 16 falling edges. The response sits in a 17-bit shift register whose bit 16 drives `sdo_o`. Each falling edge shifts the register left by one, so after falling edge k (1 to 15) `sdo_o` equals bit 16-k of the image loaded at the start of the frame. Rising edges in this phase change nothing.
- R4: On the 16th falling edge of the output phase the shift register clears, `sdo_o` becomes 0, `sdo_oe_o` falls to 0 and the input phase begins with the counter reloaded to 16.
- R5: The input phase lasts 16 rising edges. Each rising edge shifts `sdi_i` in at bit 0, so the first bit received ends up as bit 15. Falling edges in this phase change nothing. After the 16th rising edge the word appears on `cfg_o`, and `cfg_o` changes at no other time.
- R6: A configuration word whose low byte is 0x00 loads the temperature image 0x0B9F, with bit 16 at 0, for the next output phase and clears `bad_cmd_o`.
- R7: A configuration word whose low byte is 0xFF loads the identifier image 0x8100, with bit 16 at 0, and clears `bad_cmd_o`.
- R8: Any other low byte sets `bad_cmd_o` and leaves the shift register holding the word just received. The next output phase therefore shifts that word out. The next valid word clears the flag.
- R9: If `idle_req_i` is 1 when the 16th input bit arrives, the block enters an idle phase with `sdo_oe_o` at 0. It counts 16 rising edges, ignores falling edges, and then returns to the output phase with the shift register cleared, so the next frame sends all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the host, asynchronous |
| sdi_i | input | 1 | Serial data from the host, asynchronous |
| idle_req_i | input | 1 | Requests an idle frame when the input phase completes |
| sdo_o | output | 1 | Serial data to the host (shift register bit 16) |
| sdo_oe_o | output | 1 | 1 while the block is in the output phase |
| cfg_o | output | 16 | Last configuration word received |
| bad_cmd_o | output | 1 | The last configuration word had an unknown low byte |

## Verification
Frames are run with the low byte at 0x00, at 0xFF and at an arbitrary value 0x5A. A second 0xFF word follows the bad one. These patterns separate the two fixed images from the hold-the-word path, and they show whether the flag is cleared or stuck. The high bytes vary between tests so that a decoder looking at the wrong byte loads the wrong image. Every bit is sampled after each falling edge and again after the following rising edge, which catches a shift on the wrong edge or an off-by-one count. A one-cycle serial-clock pulse and a sample taken one cycle before the expected change pin down the synchroniser latency. The idle request path and a reset in the middle of a frame are run too.

// File: rtl/tsense_pkg.sv
package tsense_pkg;

    typedef enum logic [1:0] {
        PH_OUT  = 2'd0,
        PH_IN   = 2'd1,
        PH_IDLE = 2'd2
    } phase_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } sedge_t;

    typedef struct packed {
        logic out_step;
        logic out_done;
        logic in_step;
        logic in_done;
        logic idle_step;
        logic idle_done;
    } step_t;

    typedef enum logic [1:0] {
        RSP_TEMP = 2'd0,
        RSP_ID   = 2'd1,
        RSP_BAD  = 2'd2
    } rsp_e;

    localparam logic [7:0] SEL_TEMP = 8'h00;
    localparam logic [7:0] SEL_ID   = 8'hFF;

    function automatic rsp_e decode_sel(input logic [7:0] sel);
        if (sel == SEL_TEMP)    return RSP_TEMP;
        else if (sel == SEL_ID) return RSP_ID;
        else                    return RSP_BAD;
    endfunction

endpackage

// File: rtl/tsense_sync.sv
module tsense_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/tsense_frame_ctl.sv
module tsense_frame_ctl
    import tsense_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int CNT_W  = $clog2(WORD_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk_s,
    input  logic             idle_req,
    output phase_e           phase,
    output logic [CNT_W-1:0] cnt,
    output step_t            step
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic             sclk_q;
    sedge_t           ev;
    logic             fresh;
    phase_e           eff_phase;
    logic [CNT_W-1:0] eff_cnt;
    logic             last;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk_s;
    end

    always_comb begin
        ev.rise   = sclk_s & ~sclk_q;
        ev.fall   = ~sclk_s & sclk_q;
        // a zero count only occurs after reset: treat it as a fresh output phase
        fresh     = (cnt == '0);
        eff_phase = fresh ? PH_OUT : phase;
        eff_cnt   = fresh ? FULL : cnt;
        last      = (eff_cnt == ONE);
        step      = '0;
        case (eff_phase)
            PH_OUT: if (ev.fall) begin
                step.out_done = last;
                step.out_step = !last;
            end
            PH_IN: if (ev.rise) begin
                step.in_done = last;
                step.in_step = !last;
            end
            PH_IDLE: if (ev.rise) begin
                step.idle_done = last;
                step.idle_step = !last;
            end
            default: step = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_OUT;
            cnt   <= '0;
        end else if (ev.rise || ev.fall) begin
            if (step.out_done) begin
                phase <= PH_IN;
                cnt   <= FULL;
            end else if (step.in_done) begin
                phase <= idle_req ? PH_IDLE : PH_OUT;
                cnt   <= FULL;
            end else if (step.idle_done) begin
                phase <= PH_OUT;
                cnt   <= FULL;
            end else if (step.out_step || step.in_step || step.idle_step) begin
                phase <= eff_phase;
                cnt   <= eff_cnt - ONE;
            end else begin
                phase <= eff_phase;
                cnt   <= eff_cnt;
            end
        end
    end
endmodule

// File: rtl/tsense_shift.sv
module tsense_shift
    import tsense_pkg::*;
#(
    parameter int              WORD_W    = 16,
    parameter logic [WORD_W-1:0] TEMP_CODE = 16'h0B9F,
    parameter logic [WORD_W-1:0] ID_CODE   = 16'h8100
) (
    input  logic              clk,
    input  logic              rst,
    input  step_t             step,
    input  logic              sdi_s,
    output logic [WORD_W:0]   sr,
    output logic [WORD_W-1:0] cfg,
    output logic              bad
);
    logic [WORD_W:0] word_in;

    assign word_in = {sr[WORD_W-1:0], sdi_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            sr  <= '0;
            cfg <= '0;
            bad <= 1'b0;
        end else if (step.out_step) begin
            sr <= {sr[WORD_W-1:0], 1'b0};
        end else if (step.out_done || step.idle_done) begin
            sr <= '0;
        end else if (step.in_step) begin
            sr <= word_in;
        end else if (step.in_done) begin
            cfg <= word_in[WORD_W-1:0];
            case (decode_sel(word_in[7:0]))
                RSP_TEMP: begin
                    sr  <= {1'b0, TEMP_CODE};
                    bad <= 1'b0;
                end
                RSP_ID: begin
                    sr  <= {1'b0, ID_CODE};
                    bad <= 1'b0;
                end
                default: begin
                    sr  <= word_in;
                    bad <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/tsense_slave.sv
module tsense_slave
    import tsense_pkg::*;
#(
    parameter int                WORD_W      = 16,
    parameter int                SYNC_STAGES = 2,
    parameter logic [WORD_W-1:0] TEMP_CODE   = 16'h0B9F,
    parameter logic [WORD_W-1:0] ID_CODE     = 16'h8100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic              idle_req_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic [WORD_W-1:0] cfg_o,
    output logic              bad_cmd_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic [1:0]       pins_s;
    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    step_t            step;
    logic [WORD_W:0]  sr;

    tsense_sync #(
        .WIDTH (2),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  ({sclk_i, sdi_i}),
        .q  (pins_s)
    );

    tsense_frame_ctl #(
        .WORD_W(WORD_W),
        .CNT_W (CNT_W)
    ) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .sclk_s  (pins_s[1]),
        .idle_req(idle_req_i),
        .phase   (phase),
        .cnt     (cnt),
        .step    (step)
    );

    tsense_shift #(
        .WORD_W   (WORD_W),
        .TEMP_CODE(TEMP_CODE),
        .ID_CODE  (ID_CODE)
    ) u_shift (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .sdi_s(pins_s[0]),
        .sr   (sr),
        .cfg  (cfg_o),
        .bad  (bad_cmd_o)
    );

    assign sdo_o    = sr[WORD_W];
    assign sdo_oe_o = (phase == PH_OUT);
endmodule

// File: rtl/tsense_slave_chk.sv
module tsense_slave_chk
    import tsense_pkg::*;
#(
    parameter int                WORD_W    = 16,
    parameter int                CNT_W     = 5,
    parameter logic [WORD_W-1:0] TEMP_CODE = 16'h0B9F,
    parameter logic [WORD_W-1:0] ID_CODE   = 16'h8100
) (
    input logic              clk,
    input logic              rst,
    input phase_e            phase,
    input logic [CNT_W-1:0]  cnt,
    input step_t             step,
    input logic [WORD_W:0]   sr,
    input logic [WORD_W-1:0] cfg,
    input logic              bad,
    input logic              sdo_oe
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (cnt == '0 && sr == '0 && cfg == '0 && !bad && phase == PH_OUT)); // R1

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
        $onehot0(step)); // R2

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(WORD_W)); // R3

    AST_OUT_TO_IN: assert property (@(posedge clk) disable iff (rst)
        step.out_done |=> (phase == PH_IN && sr == '0 && !sdo_oe)); // R4

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !step.in_done |=> $stable(cfg)); // R5

    AST_TEMP_LOAD: assert property (@(posedge clk) disable iff (rst)
        step.in_done |=> (cfg[7:0] != SEL_TEMP || sr == {1'b0, TEMP_CODE})); // R6

    AST_ID_LOAD: assert property (@(posedge clk) disable iff (rst)
        step.in_done |=> (cfg[7:0] != SEL_ID || sr == {1'b0, ID_CODE})); // R7

    AST_BAD_FLAG: assert property (@(posedge clk) disable iff (rst)
        step.in_done |=> (bad == (cfg[7:0] != SEL_TEMP && cfg[7:0] != SEL_ID))); // R8

    AST_IDLE_EXIT: assert property (@(posedge clk) disable iff (rst)
        step.idle_done |=> (phase == PH_OUT && sr == '0)); // R9
endmodule

bind tsense_slave tsense_slave_chk #(
    .WORD_W   (WORD_W),
    .CNT_W    (CNT_W),
    .TEMP_CODE(TEMP_CODE),
    .ID_CODE  (ID_CODE)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .phase (phase),
    .cnt   (cnt),
    .step  (step),
    .sr    (sr),
    .cfg   (cfg_o),
    .bad   (bad_cmd_o),
    .sdo_oe(sdo_oe_o)
);

// File: tb/sim_tsense_slave.sv
module sim_tsense_slave;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b1;
    logic        sdi = 1'b0;
    logic        idle_req = 1'b0;
    logic        sdo;
    logic        sdo_oe;
    logic [15:0] cfg;
    logic        bad;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    localparam logic [15:0] TEMP_IMG = 16'h0B9F;
    localparam logic [15:0] ID_IMG   = 16'h8100;

    always #5 clk = ~clk;

    tsense_slave u0 (
        .clk       (clk),
        .rst       (rst),
        .sclk_i    (sclk),
        .sdi_i     (sdi),
        .idle_req_i(idle_req),
        .sdo_o     (sdo),
        .sdo_oe_o  (sdo_oe),
        .cfg_o     (cfg),
        .bad_cmd_o (bad)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic sfall();
        @(negedge clk) sclk = 1'b0;
        settle();
    endtask

    task automatic srise();
        @(negedge clk) sclk = 1'b1;
        settle();
    endtask

    // full output phase; img is the expected 17-bit shift register image
    task automatic run_out(input logic [16:0] img, input string tag);
        chk(sdo_oe == 1'b1, {tag, " R3 oe at frame start"}, 32'(sdo_oe), 32'd1);
        chk(sdo == img[16], {tag, " R3 bit before first fall"}, 32'(sdo), 32'(img[16]));
        for (int k = 1; k <= 16; k++) begin
            sfall();
            if (k < 16) begin
                chk(sdo == img[16-k], {tag, " R3 bit after fall"}, 32'(sdo), 32'(img[16-k]));
                srise();
                chk(sdo == img[16-k], {tag, " R3 rise ignored"}, 32'(sdo), 32'(img[16-k]));
            end else begin
                chk(sdo == 1'b0, {tag, " R4 cleared"}, 32'(sdo), 32'd0);
                chk(sdo_oe == 1'b0, {tag, " R4 input phase"}, 32'(sdo_oe), 32'd0);
            end
        end
    endtask

    // full input phase, MSB first
    task automatic run_in(input logic [15:0] word, input bit idle, input string tag);
        idle_req = idle;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk) sdi = word[15-i];
            srise();
            if (i < 15) begin
                sfall();
                chk(sdo_oe == 1'b0, {tag, " R5 still input"}, 32'(sdo_oe), 32'd0);
            end
        end
        chk(cfg == word, {tag, " R5 cfg word"}, 32'(cfg), 32'(word));
        chk(sdo_oe == !idle, {tag, " R5/R9 phase after input"}, 32'(sdo_oe), 32'(!idle));
        idle_req = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk(sdo_oe == 1'b1, "R1 oe after reset", 32'(sdo_oe), 32'd1);
        chk(sdo == 1'b0, "R1 sdo after reset", 32'(sdo), 32'd0);
        chk(cfg == 16'h0, "R1 cfg after reset", 32'(cfg), 32'd0);
        chk(bad == 1'b0, "R1 flag after reset", 32'(bad), 32'd0);
        run_out(17'h0, "R1 first frame");
    endtask

    task automatic t_temp();
        run_in(16'h3C00, 1'b0, "R6");
        chk(bad == 1'b0, "R6 flag clear", 32'(bad), 32'd0);
        run_out({1'b0, TEMP_IMG}, "R6 temp frame");
    endtask

    task automatic t_id();
        run_in(16'h5AFF, 1'b0, "R7");
        chk(bad == 1'b0, "R7 flag clear", 32'(bad), 32'd0);
        run_out({1'b0, ID_IMG}, "R7 id frame");
    endtask

    task automatic t_bad();
        run_in(16'hA55A, 1'b0, "R8");
        chk(bad == 1'b1, "R8 flag set", 32'(bad), 32'd1);
        run_out({1'b0, 16'hA55A}, "R8 held word");
        run_in(16'h00FF, 1'b0, "R8 recover");
        chk(bad == 1'b0, "R8 flag cleared", 32'(bad), 32'd0);
    endtask

    // continues from t_bad: the ID image is loaded
    task automatic t_sync();
        logic [16:0] img;
        img = {1'b0, ID_IMG};
        @(negedge clk) sclk = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk(sdo == img[16], "R2 no change before sync delay", 32'(sdo), 32'(img[16]));
        @(posedge clk);
        @(negedge clk);
        chk(sdo == img[15], "R2 change on third edge", 32'(sdo), 32'(img[15]));
        @(negedge clk) sclk = 1'b1;
        settle();
        for (int k = 2; k <= 16; k++) begin
            @(negedge clk) sclk = 1'b0;
            if (k < 16) begin
                @(negedge clk) sclk = 1'b1;
                settle();
                chk(sdo == img[16-k], "R2 short pulse bit", 32'(sdo), 32'(img[16-k]));
            end else begin
                settle();
                chk(sdo_oe == 1'b0, "R2 16 short pulses end phase", 32'(sdo_oe), 32'd0);
            end
        end
    endtask

    task automatic t_idle();
        run_in(16'h7700, 1'b1, "R9");
        chk(bad == 1'b0, "R9 valid word", 32'(bad), 32'd0);
        for (int i = 1; i <= 16; i++) begin
            sfall();
            srise();
            if (i < 16)
                chk(sdo_oe == 1'b0, "R9 idle quiet", 32'(sdo_oe), 32'd0);
            else
                chk(sdo_oe == 1'b1, "R9 idle exit", 32'(sdo_oe), 32'd1);
        end
        run_out(17'h0, "R9 cleared frame");
    endtask

    task automatic t_midreset();
        run_in(16'h12FF, 1'b0, "R1 pre");
        for (int i = 0; i < 3; i++) begin
            sfall();
            srise();
        end
        @(negedge clk) rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk(sdo == 1'b0, "R1 mid-frame sdo", 32'(sdo), 32'd0);
        chk(sdo_oe == 1'b1, "R1 mid-frame oe", 32'(sdo_oe), 32'd1);
        chk(cfg == 16'h0, "R1 mid-frame cfg", 32'(cfg), 32'd0);
        run_out(17'h0, "R1 frame after reset");
    endtask

    initial begin
        t_reset();
        t_temp();
        t_id();
        t_bad();
        t_sync();
        run_in(16'hC300, 1'b0, "R5 after sync");
        run_out({1'b0, TEMP_IMG}, "R6 after sync");
        t_idle();
        t_midreset();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule